// File: doc/BRIEF.md
# Dirty Victim Router

This block sits behind a private first-level data cache and handles every line that cache evicts. A clean victim needs no copy anywhere, so it is accepted and discarded in a single cycle. A dirty victim has to land in a higher level. The block first probes the tags of the non-inclusive second level. On a hit, it updates that second-level entry. On a miss, it sends the line straight to the inclusive third level, which always holds an entry for it. The block never allocates a new second-level entry for such a line.

The victim interface uses a valid/ready handshake and takes one victim at a time. While a dirty line is in flight, the block compares incoming read requests against its address. A matching read is held off until the writeback completes, so it never returns stale data. Each victim produces exactly one one-cycle strobe that names its outcome, for use by external event counters.

Top module: `victim_router`

## Requirements
- R1: A clean victim (dirty flag 0) is accepted in the cycle it is offered while `vic_ready_o` is high. No probe and no write to either level follows, and `cnt_clean_o` is high for exactly the one cycle after acceptance.
- R2: In the cycle after a dirty victim is accepted, `probe_req_o` is high with `probe_addr_o` equal to the victim address. `vic_ready_o` stays low from that cycle until the chosen destination accepts the write.
- R3: If `probe_hit_i` is high in the probe cycle, the next cycle raises `l2_wr_valid_o` with the victim address and data. `l3_wr_valid_o` stays low for that victim.
- R4: If `probe_hit_i` is low in the probe cycle, the next cycle raises `l3_wr_valid_o` with the victim address and data. `l2_wr_valid_o` stays low, so no second-level entry is written or allocated.
- R5: The destination is decided by the registered probe result. Once a write is raised, its valid, address and data hold unchanged until the matching ready is high at a clock edge. A later change on `probe_hit_i` has no effect on the destination.
- R6: While a dirty victim is pending (from the probe cycle through the cycle its write is accepted), `rd_stall_o` is high whenever `rd_valid_i` is high and `rd_addr_i` equals the victim's line address. A read to any other address, or any read once the block is idle, is not stalled.
- R7: In the cycle after a write is accepted, exactly one strobe is high: `cnt_l2_o` for a second-level write, `cnt_l3_o` for a third-level write. In that same cycle `vic_ready_o` is high again.
- R8: During and right after reset, `vic_ready_o` is high. No probe, write or strobe is raised until a victim is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vic_valid_i | input | 1 | Victim offered |
| vic_ready_o | output | 1 | Router can take a victim |
| vic_addr_i | input | ADDR_W | Victim line address |
| vic_dirty_i | input | 1 | Victim is modified |
| vic_data_i | input | DATA_W | Victim line data |
| probe_req_o | output | 1 | Second-level tag probe request |
| probe_addr_o | output | ADDR_W | Probe address |
| probe_hit_i | input | 1 | Probe result, valid in the probe cycle |
| l2_wr_valid_o | output | 1 | Second-level update request |
| l2_wr_ready_i | input | 1 | Second level accepts the update |
| l2_wr_addr_o | output | ADDR_W | Second-level update address |
| l2_wr_data_o | output | DATA_W | Second-level update data |
| l3_wr_valid_o | output | 1 | Third-level write request |
| l3_wr_ready_i | input | 1 | Third level accepts the write |
| l3_wr_addr_o | output | ADDR_W | Third-level write address |
| l3_wr_data_o | output | DATA_W | Third-level write data |
| rd_valid_i | input | 1 | Read request present |
| rd_addr_i | input | ADDR_W | Read line address |
| rd_stall_o | output | 1 | Read must wait |
| cnt_clean_o | output | 1 | Clean-drop strobe |
| cnt_l2_o | output | 1 | Second-level write strobe |
| cnt_l3_o | output | 1 | Third-level bypass strobe |

## Verification
The case hardest to reach is a dirty write held back by its destination for several cycles while other signals move around it. During that wait, reads to the same line and to a neighbouring line are offered. After the probe cycle, `probe_hit_i` is also flipped to the opposite value. Together these show that the stall tracks the pending address only, and that the destination cannot change once the probe result is registered. The vector table gives each dirty victim its own number of back-pressure cycles. The hit and miss cases are interleaved with clean drops, so every path is entered from every other path.

// File: rtl/vr_pkg.sv
package vr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_SEND  = 2'd2
  } vr_state_e;

  typedef enum logic [1:0] {
    OUT_CLEAN = 2'd0,
    OUT_MID   = 2'd1,
    OUT_OUTER = 2'd2
  } vr_outcome_e;

  localparam int unsigned NUM_OUTCOMES = 3;
endpackage

// File: rtl/vr_victim_buf.sv
module vr_victim_buf #(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/vr_hazard.sv
module vr_hazard #(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned OFS_W  = 0
) (
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              pend_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  output logic              stall_o
);
  logic match;

  // OFS_W low bits select a word inside the line and are ignored
  generate
    if (OFS_W == 0) begin : g_full
      assign match = (rd_addr_i == pend_addr_i);
    end else begin : g_line
      assign match = (rd_addr_i[ADDR_W-1:OFS_W] == pend_addr_i[ADDR_W-1:OFS_W]);
    end
  endgenerate

  assign stall_o = rd_valid_i & pend_i & match;
endmodule

// File: rtl/vr_stat.sv
module vr_stat
  import vr_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ev_i,
  input  vr_outcome_e             kind_i,
  output logic [NUM_OUTCOMES-1:0] strobe_o
);
  logic [NUM_OUTCOMES-1:0] strobe_q;

  for (genvar i = 0; i < NUM_OUTCOMES; i++) begin : g_strobe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) strobe_q[i] <= 1'b0;
      else         strobe_q[i] <= ev_i && (kind_i == vr_outcome_e'(i));
    end
  end

  assign strobe_o = strobe_q;

  p_one_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_q));
endmodule

// File: rtl/victim_router.sv
module victim_router
  import vr_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned DATA_W = 128,
  parameter int unsigned OFS_W  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vic_valid_i,
  output logic              vic_ready_o,
  input  logic [ADDR_W-1:0] vic_addr_i,
  input  logic              vic_dirty_i,
  input  logic [DATA_W-1:0] vic_data_i,
  output logic              probe_req_o,
  output logic [ADDR_W-1:0] probe_addr_o,
  input  logic              probe_hit_i,
  output logic              l2_wr_valid_o,
  input  logic              l2_wr_ready_i,
  output logic [ADDR_W-1:0] l2_wr_addr_o,
  output logic [DATA_W-1:0] l2_wr_data_o,
  output logic              l3_wr_valid_o,
  input  logic              l3_wr_ready_i,
  output logic [ADDR_W-1:0] l3_wr_addr_o,
  output logic [DATA_W-1:0] l3_wr_data_o,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_stall_o,
  output logic              cnt_clean_o,
  output logic              cnt_l2_o,
  output logic              cnt_l3_o
);
  vr_state_e               state_q, state_d;
  logic                    hit_q;
  logic                    accept, load, done, pend, ev;
  vr_outcome_e             kind;
  logic [ADDR_W-1:0]       buf_addr;
  logic [DATA_W-1:0]       buf_data;
  logic [NUM_OUTCOMES-1:0] strobe;

  assign vic_ready_o = (state_q == ST_IDLE);
  assign accept      = vic_valid_i & vic_ready_o;
  assign load        = accept & vic_dirty_i;
  assign pend        = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load) state_d = ST_PROBE;
      ST_PROBE: state_d = ST_SEND;
      ST_SEND:  if (done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_PROBE) hit_q <= probe_hit_i;
    end
  end

  vr_victim_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (vic_addr_i),
    .data_i (vic_data_i),
    .addr_o (buf_addr),
    .data_o (buf_data)
  );

  assign probe_req_o  = (state_q == ST_PROBE);
  assign probe_addr_o = buf_addr;

  assign l2_wr_valid_o = (state_q == ST_SEND) &  hit_q;
  assign l3_wr_valid_o = (state_q == ST_SEND) & ~hit_q;
  assign l2_wr_addr_o  = buf_addr;
  assign l2_wr_data_o  = buf_data;
  assign l3_wr_addr_o  = buf_addr;
  assign l3_wr_data_o  = buf_data;

  assign done = (l2_wr_valid_o & l2_wr_ready_i) | (l3_wr_valid_o & l3_wr_ready_i);

  vr_hazard #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_hazard (
    .rd_valid_i  (rd_valid_i),
    .rd_addr_i   (rd_addr_i),
    .pend_i      (pend),
    .pend_addr_i (buf_addr),
    .stall_o     (rd_stall_o)
  );

  // accept and done never coincide: one needs IDLE, the other SEND
  assign ev   = (accept & ~vic_dirty_i) | done;
  assign kind = done ? (hit_q ? OUT_MID : OUT_OUTER) : OUT_CLEAN;

  vr_stat i_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .kind_i   (kind),
    .strobe_o (strobe)
  );

  assign cnt_clean_o = strobe[OUT_CLEAN];
  assign cnt_l2_o    = strobe[OUT_MID];
  assign cnt_l3_o    = strobe[OUT_OUTER];

  p_clean_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vic_valid_i && vic_ready_o && !vic_dirty_i |=>
      cnt_clean_o && !probe_req_o && !l2_wr_valid_o && !l3_wr_valid_o);

  p_probe_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vic_valid_i && vic_ready_o && vic_dirty_i |=>
      probe_req_o && !vic_ready_o && probe_addr_o == $past(vic_addr_i));

  p_write_after_probe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_req_o |=> (l2_wr_valid_o == $past(probe_hit_i)) && (l3_wr_valid_o == !$past(probe_hit_i)));

  p_single_dest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({l2_wr_valid_o, l3_wr_valid_o, probe_req_o}));

  p_hold_l2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_wr_valid_o && !l2_wr_ready_i |=>
      l2_wr_valid_o && $stable(l2_wr_addr_o) && $stable(l2_wr_data_o));

  p_hold_l3_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l3_wr_valid_o && !l3_wr_ready_i |=>
      l3_wr_valid_o && $stable(l3_wr_addr_o) && $stable(l3_wr_data_o));

  p_stall_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i && (l2_wr_valid_o || l3_wr_valid_o || probe_req_o) && rd_addr_i == probe_addr_o
      |-> rd_stall_o);

  p_no_stall_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vic_ready_o |-> !rd_stall_o);

  p_strobe_after_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l2_wr_valid_o && l2_wr_ready_i) || (l3_wr_valid_o && l3_wr_ready_i) |=>
      vic_ready_o && (cnt_l2_o || cnt_l3_o));
endmodule

// File: tb/test_victim_router.sv
module test_victim_router;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 32;
  localparam time         CLK_PER  = 10ns;
  localparam int unsigned WDOG_CYC = 20000;

  typedef struct packed {
    logic              dirty;
    logic              hit;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [3:0]        wait_c;
  } vec_t;

  localparam int unsigned NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b0, 16'h0040, 32'h1111_0000, 4'd0},
    '{1'b1, 1'b1, 16'h0100, 32'hA5A5_0001, 4'd0},
    '{1'b1, 1'b0, 16'h0200, 32'h5A5A_0002, 4'd0},
    '{1'b1, 1'b1, 16'h0301, 32'hDEAD_0003, 4'd3},
    '{1'b0, 1'b1, 16'h0300, 32'h2222_0004, 4'd0},
    '{1'b1, 1'b0, 16'hFFFF, 32'hBEEF_0005, 4'd5},
    '{1'b1, 1'b0, 16'h0000, 32'hFFFF_FFFF, 4'd1},
    '{1'b0, 1'b0, 16'h7777, 32'h3333_0007, 4'd0},
    '{1'b1, 1'b1, 16'h8000, 32'h0000_0000, 4'd2},
    '{1'b1, 1'b0, 16'h1234, 32'hCAFE_0009, 4'd0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              vic_valid = 1'b0, vic_dirty = 1'b0;
  logic [ADDR_W-1:0] vic_addr = '0;
  logic [DATA_W-1:0] vic_data = '0;
  logic              probe_hit = 1'b0;
  logic              l2_ready = 1'b0, l3_ready = 1'b0;
  logic              rd_valid = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              vic_ready, probe_req, l2_valid, l3_valid, rd_stall;
  logic              cnt_clean, cnt_l2, cnt_l3;
  logic [ADDR_W-1:0] probe_addr, l2_addr, l3_addr;
  logic [DATA_W-1:0] l2_data, l3_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  victim_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_victim_router (
    .clk_i(clk), .rst_ni(rst_n),
    .vic_valid_i(vic_valid), .vic_ready_o(vic_ready), .vic_addr_i(vic_addr),
    .vic_dirty_i(vic_dirty), .vic_data_i(vic_data),
    .probe_req_o(probe_req), .probe_addr_o(probe_addr), .probe_hit_i(probe_hit),
    .l2_wr_valid_o(l2_valid), .l2_wr_ready_i(l2_ready), .l2_wr_addr_o(l2_addr), .l2_wr_data_o(l2_data),
    .l3_wr_valid_o(l3_valid), .l3_wr_ready_i(l3_ready), .l3_wr_addr_o(l3_addr), .l3_wr_data_o(l3_data),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_stall_o(rd_stall),
    .cnt_clean_o(cnt_clean), .cnt_l2_o(cnt_l2), .cnt_l3_o(cnt_l3)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  // sample point: 1 time unit after the falling edge
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic quiet(input string req);
    chk_eq(req, "vic_ready", vic_ready, 1);
    chk_eq(req, "probe/wr valid", {probe_req, l2_valid, l3_valid}, 0);
  endtask

  task automatic run_vec(input vec_t v);
    // offer victim
    vic_valid = 1'b1; vic_dirty = v.dirty; vic_addr = v.addr; vic_data = v.data;
    #1;
    chk_eq("R2", "ready at offer", vic_ready, 1);
    step();
    vic_valid = 1'b0; vic_addr = ~v.addr; vic_data = ~v.data;
    if (!v.dirty) begin
      #1;
      chk_eq("R1", "clean strobe", {cnt_clean, cnt_l2, cnt_l3}, 3'b100);
      quiet("R1");
      step();
      chk_eq("R1", "strobe one cycle", {cnt_clean, cnt_l2, cnt_l3}, 3'b000);
      return;
    end
    probe_hit = v.hit;
    #1;
    chk_eq("R2", "probe_req", probe_req, 1);
    chk_eq("R2", "probe_addr", probe_addr, v.addr);
    chk_eq("R2", "ready low in probe", vic_ready, 0);
    rd_valid = 1'b1; rd_addr = v.addr;
    #1;
    chk_eq("R6", "stall in probe", rd_stall, 1);
    step();
    probe_hit = ~v.hit;   // R5: must not steer the destination now
    rd_addr = v.addr ^ 16'h0001;
    for (int w = 0; w <= int'(v.wait_c); w++) begin
      if (w == int'(v.wait_c)) begin
        l2_ready = 1'b1; l3_ready = 1'b1;
      end
      #1;
      chk_eq(v.hit ? "R3" : "R4", "l2/l3 valid", {l2_valid, l3_valid}, v.hit ? 2'b10 : 2'b01);
      chk_eq("R5", "wr addr", v.hit ? l2_addr : l3_addr, v.addr);
      chk_eq("R5", "wr data", v.hit ? l2_data : l3_data, v.data);
      chk_eq("R2", "ready low while pending", vic_ready, 0);
      chk_eq("R6", "other addr not stalled", rd_stall, 0);
      rd_addr = v.addr;
      #1;
      chk_eq("R6", "same addr stalled", rd_stall, 1);
      rd_addr = v.addr ^ 16'h0001;
      step();
    end
    l2_ready = 1'b0; l3_ready = 1'b0; probe_hit = 1'b0;
    rd_addr = v.addr;
    #1;
    chk_eq("R7", "outcome strobe", {cnt_clean, cnt_l2, cnt_l3}, v.hit ? 3'b010 : 3'b001);
    quiet("R7");
    chk_eq("R6", "no stall after done", rd_stall, 0);
    rd_valid = 1'b0;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WDOG_CYC);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    step();
    quiet("R8");
    chk_eq("R8", "strobes in reset", {cnt_clean, cnt_l2, cnt_l3}, 0);
    chk_eq("R8", "stall in reset", rd_stall, 0);
    step();
    rst_n = 1'b1;
    step();
    quiet("R8");
    chk_eq("R8", "strobes after reset", {cnt_clean, cnt_l2, cnt_l3}, 0);

    for (int i = 0; i < int'(NVEC); i++) begin
      @(negedge clk);
      run_vec(VEC[i]);
    end

    // R1: back-to-back clean victims, one strobe per victim
    @(negedge clk);
    vic_valid = 1'b1; vic_dirty = 1'b0; vic_addr = 16'h0AAA;
    step();
    chk_eq("R1", "b2b first strobe", cnt_clean, 1);
    chk_eq("R1", "b2b ready", vic_ready, 1);
    step();
    chk_eq("R1", "b2b second strobe", cnt_clean, 1);
    vic_valid = 1'b0;
    step();
    chk_eq("R1", "b2b strobe ends", cnt_clean, 0);
    quiet("R1");

    // R6: read during a clean drop is never stalled
    @(negedge clk);
    vic_valid = 1'b1; vic_dirty = 1'b0; vic_addr = 16'h0BBB;
    rd_valid = 1'b1; rd_addr = 16'h0BBB;
    #1;
    chk_eq("R6", "clean drop no stall", rd_stall, 0);
    step();
    vic_valid = 1'b0;
    #1;
    chk_eq("R6", "after clean no stall", rd_stall, 0);
    rd_valid = 1'b0;

    // R8: reset in the middle of a pending dirty victim
    @(negedge clk);
    vic_valid = 1'b1; vic_dirty = 1'b1; vic_addr = 16'h0CCC; vic_data = 32'h1234_5678;
    step();
    vic_valid = 1'b0;
    step();
    rst_n = 1'b0;
    #1;
    quiet("R8");
    step();
    rst_n = 1'b1;
    step();
    quiet("R8");
    chk_eq("R8", "no strobe after abort", {cnt_clean, cnt_l2, cnt_l3}, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule